// File: doc/BRIEF.md
# Serial Peripheral Slave, Second-Edge Sampling

This block is the target side of a four-wire serial peripheral link. It runs only in the timing variant where the first clock transition of a byte drives data and the following transition samples it. An external controller drives the serial clock, the data-in line and an active-low select. The block answers on its data-out line. The serial clock idle level is chosen by a polarity input. Either end of the byte may go first, set by a bit-order input. All three serial pins pass through a two-flop synchronizer and are handled in the system clock domain.

On the system side there is a write strobe that loads the transmit register. There is also a receive register, filled only when a whole byte has arrived, and a completion flag that a read strobe clears. If the select line is held low from one byte to the next, the block sends back the byte it just received instead of the transmit register. The select line must stay high for a programmed number of system clocks for the transmit register to be used again. That count stands for half a serial clock period. The data-out pin is meant to feed a tristate pad. A separate enable output is high only while the block is selected.

Top module: `spiPhase1Slave`

## Requirements
- R1: After reset, `doneFlag` is 0, `rxData` is 0x00 and `misoOe` is 0.
- R2: With `lsbFirst`=0, transmit bit 7 appears on `miso` after the first (leading) serial clock edge of a byte, and each later leading edge presents the next lower bit.
- R3: With `lsbFirst`=1, both directions run least significant bit first: bit 0 goes out first, and the first sampled input bit lands in `rxData` bit 0.
- R4: The input bit is sampled on each trailing edge. `rxData` changes only when the eighth trailing edge completes a byte, and it then holds the whole assembled byte.
- R5: `doneFlag` sets when a byte completes. A cycle with `rxRdEn`=1 clears it. If a read and a completion fall in the same cycle, the flag stays set.
- R6: When `ssN` stays low between two bytes, the second byte sends the previously received byte, and any write to the transmit register is not used for it.
- R7: When `ssN` is high for at least `halfCycles` synchronized system clocks between bytes, the next byte sends the transmit register. A shorter high pulse behaves as in R6.
- R8: Raising `ssN` in the middle of a byte discards the partial byte. `rxData` and `doneFlag` do not change, and the next byte starts from its first bit.
- R9: `misoOe` is 0 while `ssN` is high and 1 while it is low, after the synchronizer delay.
- R10: With `cpol`=1 the clock idles high. The falling edge is then the leading edge and the rising edge is the trailing edge, and the data behaviour of R2 to R4 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| lsbFirst | input | 1 | 1: least significant bit first |
| halfCycles | input | CNT_W | Minimum select-high time in system clocks |
| txWrEn | input | 1 | Write strobe for the transmit register |
| txWrData | input | DATA_W | Transmit register write data |
| rxRdEn | input | 1 | Read strobe; clears the completion flag |
| rxData | output | DATA_W | Receive register |
| doneFlag | output | 1 | Byte-complete flag |
| sck | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| ssN | input | 1 | Active-low select |
| miso | output | 1 | Serial data to the controller |
| misoOe | output | 1 | Output enable for the data-out pad |

## Verification
The bench holds select low across two bytes and writes a new transmit value in between. A design that ignored the held select would send that new value instead of the echo. It runs select-high gaps one clock short of the programmed count and exactly at it, which exposes an off-by-one in the gap counter as the wrong byte on `miso`. It aborts a byte after three bits and checks that neither `rxData` nor the flag moved and that the following byte starts cleanly. A counter that failed to clear on deselect would shift the later byte. A read strobe is placed in the cycle a byte completes, so a design that gave the clear priority would lose the flag.

// File: rtl/spiSlavePkg.sv
package spiSlavePkg;

  // Per-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadShift;  // first leading edge: load outgoing byte
    logic shiftIn;    // later leading edge: shift, insert held input bit
    logic latchIn;    // trailing edge: sample data-in
    logic complete;   // last trailing edge of a byte
    logic pickTx;     // outgoing byte comes from the transmit register
  } xferCtl_t;

endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RESET_VAL;
          else       stage[s] <= pinIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RESET_VAL;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign pinOut = stage[STAGES-1];

endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiSlavePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             ssNS,
  input  logic             cpol,
  input  logic [CNT_W-1:0] halfCycles,
  output xferCtl_t         ctl,
  output logic             selActive,
  output logic [BIT_W-1:0] bitCnt
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic             sckD;
  logic             leadEdge;
  logic             trailEdge;
  logic [CNT_W-1:0] gapCnt;
  logic             gapMet;

  assign selActive = !ssNS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckD <= 1'b0;
    else       sckD <= sckS;
  end

  // Leading edge leaves the idle level, trailing edge returns to it.
  assign leadEdge  = selActive && (sckD == cpol) && (sckS != cpol);
  assign trailEdge = selActive && (sckD != cpol) && (sckS == cpol);

  always_comb begin
    ctl           = '0;
    ctl.loadShift = leadEdge && (bitCnt == '0);
    ctl.shiftIn   = leadEdge && (bitCnt != '0);
    ctl.latchIn   = trailEdge;
    ctl.complete  = trailEdge && (bitCnt == LAST_BIT);
    ctl.pickTx    = gapMet;
  end

  // Trailing edges counted; a deselect throws away a partial byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (!selActive)      bitCnt <= '0;
    else if (ctl.complete)    bitCnt <= '0;
    else if (trailEdge)       bitCnt <= bitCnt + 1'b1;
  end

  // Select-high time, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (selActive)       gapCnt <= '0;
    else if (gapCnt != '1)    gapCnt <= gapCnt + 1'b1;
  end

  // A finished byte arms the echo; a long enough gap disarms it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       gapMet <= 1'b1;
    else if (ctl.complete)           gapMet <= 1'b0;
    else if (gapCnt >= halfCycles)   gapMet <= 1'b1;
  end

endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiSlavePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCtl_t          ctl,
  input  logic              lsbFirst,
  input  logic              mosiS,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              misoBit
);

  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] srcByte;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] finalByte;
  logic [DATA_W-1:0] nextShift;
  logic              heldBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       txReg <= '0;
    else if (txWrEn) txReg <= txWrData;
  end

  // Receive register doubles as the echo source.
  assign srcByte   = ctl.pickTx ? txReg : rxData;
  assign shifted   = lsbFirst ? {heldBit, shiftReg[DATA_W-1:1]}
                              : {shiftReg[DATA_W-2:0], heldBit};
  assign finalByte = lsbFirst ? {mosiS, shiftReg[DATA_W-1:1]}
                              : {shiftReg[DATA_W-2:0], mosiS};

  always_comb begin
    nextShift = shiftReg;
    if (ctl.loadShift)    nextShift = srcByte;
    else if (ctl.shiftIn) nextShift = shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      misoBit  <= 1'b0;
    end else if (ctl.loadShift || ctl.shiftIn) begin
      shiftReg <= nextShift;
      misoBit  <= lsbFirst ? nextShift[0] : nextShift[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           heldBit <= 1'b0;
    else if (ctl.latchIn) heldBit <= mosiS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxData <= '0;
    else if (ctl.complete) rxData <= finalByte;
  end

  // Set has priority over a same-cycle read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             doneFlag <= 1'b0;
    else if (ctl.complete) doneFlag <= 1'b1;
    else if (rxRdEn)       doneFlag <= 1'b0;
  end

endmodule

// File: rtl/spiPhase1Slave.sv
module spiPhase1Slave
  import spiSlavePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic [CNT_W-1:0]  halfCycles,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ssN,
  output logic              miso,
  output logic              misoOe
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [2:0]       pinSync;
  logic             ssNS;
  logic             sckS;
  logic             mosiS;
  xferCtl_t         ctl;
  logic             selActive;
  logic [BIT_W-1:0] bitCnt;

  spiPinSync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .pinIn({ssN, sck, mosi}),
    .pinOut(pinSync)
  );
  assign {ssNS, sckS, mosiS} = pinSync;

  spiCtrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .ssNS(ssNS), .cpol(cpol),
    .halfCycles(halfCycles), .ctl(ctl), .selActive(selActive), .bitCnt(bitCnt)
  );

  spiDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lsbFirst(lsbFirst), .mosiS(mosiS),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn),
    .rxData(rxData), .doneFlag(doneFlag), .misoBit(miso)
  );

  assign misoOe = selActive;

endmodule

// File: rtl/spiPhase1SlaveChecker.sv
module spiPhase1SlaveChecker #(
  parameter int DATA_W = 8,
  parameter int BIT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              selActive,
  input logic              complete,
  input logic              rdEn,
  input logic              doneFlag,
  input logic [DATA_W-1:0] rxData,
  input logic [BIT_W-1:0]  bitCnt
);

  a_r4_rx_only_on_complete: assert property (@(posedge clk) disable iff (!rstN)
    !$past(complete) |-> $stable(rxData));

  a_r5_set_on_complete: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> doneFlag);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !complete && doneFlag) |=> !doneFlag);

  a_r5_rise_needs_complete: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(complete));

  a_r8_deselect_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> (bitCnt == '0));

endmodule

bind spiPhase1Slave spiPhase1SlaveChecker #(.DATA_W(DATA_W), .BIT_W(BIT_W)) uChk (
  .clk(clk), .rstN(rstN), .selActive(selActive), .complete(ctl.complete),
  .rdEn(rxRdEn), .doneFlag(doneFlag), .rxData(rxData), .bitCnt(bitCnt)
);

// File: tb/spiPhase1Slave_test.sv
module spiPhase1Slave_test;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpol = 1'b0;
  logic       lsbFirst = 1'b0;
  logic [7:0] halfCycles = 8'(HALF);
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = 8'h00;
  logic       rxRdEn = 1'b0;
  logic [7:0] rxData;
  logic       doneFlag;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       ssN = 1'b1;
  logic       miso;
  logic       misoOe;

  int vectors = 0;
  int fails = 0;

  // Behavioural reference state
  logic [7:0] mTx = 8'h00;
  logic [7:0] mRx = 8'h00;
  logic       mFlag = 1'b0;
  bit         mGapOk = 1'b1;
  bit         live = 1'b0;

  always #5 clk = ~clk;

  spiPhase1Slave uut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .lsbFirst(lsbFirst),
    .halfCycles(halfCycles), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxRdEn(rxRdEn), .rxData(rxData), .doneFlag(doneFlag),
    .sck(sck), .mosi(mosi), .ssN(ssN), .miso(miso), .misoOe(misoOe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (live) begin
      chk(doneFlag == mFlag, "R5 flag", {7'b0, doneFlag}, {7'b0, mFlag});
      chk(rxData == mRx, "R4 rxData", rxData, mRx);
    end
  end

  task automatic writeTx(input logic [7:0] v);
    @(negedge clk); txWrEn = 1'b1; txWrData = v; mTx = v;
    @(negedge clk); txWrEn = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk); rxRdEn = 1'b1; mFlag = 1'b0;
    @(negedge clk); rxRdEn = 1'b0;
  endtask

  task automatic gap(input int n, input bit checkOe);
    @(negedge clk); ssN = 1'b1;
    repeat (n) @(negedge clk);
    if (checkOe) chk(misoOe == 1'b0, "R9 deselected oe", {7'b0, misoOe}, 8'h00);
    ssN = 1'b0;
    if (n >= HALF) mGapOk = 1'b1;
    repeat (4) @(negedge clk);
    chk(misoOe == 1'b1, "R9 selected oe", {7'b0, misoOe}, 8'h01);
  endtask

  task automatic xfer(input logic [7:0] din, input int nBits, input bit readAtEnd, input string req);
    logic [7:0] src;
    src = mGapOk ? mTx : mRx;
    for (int i = 0; i < nBits; i++) begin
      int idx;
      idx = lsbFirst ? i : 7 - i;
      @(negedge clk); sck = ~sck; mosi = din[idx];
      repeat (7) @(negedge clk);
      chk(miso == src[idx], req, {7'b0, miso}, {7'b0, src[idx]});
      @(negedge clk); sck = ~sck;
      if (i == 7) begin
        repeat (2) @(negedge clk);
        mRx = din; mFlag = 1'b1; mGapOk = 1'b0;
        if (readAtEnd) begin
          rxRdEn = 1'b1;
          @(negedge clk); rxRdEn = 1'b0;
          repeat (4) @(negedge clk);
        end else repeat (5) @(negedge clk);
      end else repeat (7) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(doneFlag == 1'b0, "R1 flag", {7'b0, doneFlag}, 8'h00);
    chk(rxData == 8'h00, "R1 rxData", rxData, 8'h00);
    chk(misoOe == 1'b0, "R1 oe", {7'b0, misoOe}, 8'h00);
    live = 1'b1;

    // R2 R4 R5: MSB first from transmit register
    writeTx(8'hA5);
    gap(10, 1'b1);
    xfer(8'h3C, 8, 1'b0, "R2 msb-first miso");
    chk(rxData == 8'h3C, "R4 assembled byte", rxData, 8'h3C);
    readRx();
    chk(doneFlag == 1'b0, "R5 read clears", {7'b0, doneFlag}, 8'h00);

    // R6: select held low, new tx write is not used
    writeTx(8'h5A);
    xfer(8'h81, 8, 1'b0, "R6 echo last byte");

    // R7: gap one short of the count, then exactly the count
    gap(HALF - 1, 1'b0);
    xfer(8'h0F, 8, 1'b0, "R7 short gap echoes");
    gap(HALF, 1'b0);
    xfer(8'hF0, 8, 1'b1, "R7 full gap sends tx");
    chk(doneFlag == 1'b1, "R5 set beats read", {7'b0, doneFlag}, 8'h01);
    readRx();

    // R3: LSB first
    lsbFirst = 1'b1;
    writeTx(8'h1E);
    gap(20, 1'b1);
    xfer(8'hB2, 8, 1'b0, "R3 lsb-first miso");
    chk(rxData == 8'hB2, "R3 lsb-first rx", rxData, 8'hB2);
    readRx();

    // R10: clock idles high
    lsbFirst = 1'b0;
    @(negedge clk); ssN = 1'b1; cpol = 1'b1; sck = 1'b1;
    writeTx(8'h6D);
    gap(20, 1'b1);
    xfer(8'h92, 8, 1'b0, "R10 cpol1 miso");
    chk(rxData == 8'h92, "R10 cpol1 rx", rxData, 8'h92);
    readRx();

    // R8: abort after three bits, then a clean byte
    gap(20, 1'b0);
    xfer(8'hFF, 3, 1'b0, "R8 partial miso");
    sck = 1'b1;
    gap(20, 1'b1);
    chk(rxData == 8'h92, "R8 partial discarded", rxData, 8'h92);
    chk(doneFlag == 1'b0, "R8 no flag", {7'b0, doneFlag}, 8'h00);
    xfer(8'h44, 8, 1'b0, "R8 restart miso");
    chk(rxData == 8'h44, "R8 restart rx", rxData, 8'h44);

    @(negedge clk); ssN = 1'b1;
    repeat (6) @(negedge clk);
    chk(misoOe == 1'b0, "R9 final deselect", {7'b0, misoOe}, 8'h00);
    live = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule